// File: doc/BRIEF.md
# Transmit Marker Insertion Controller

This block sits on the read side of a first-word-fall-through transmit FIFO and feeds one character per character-clock cycle to an 8B/10B encoder. Each FIFO word holds a data byte and three tag bits: a start-of-cell flag, a special/data flag and a service flag. When a word with the start-of-cell flag set reaches the FIFO head, the block first sends a control (K) character that tells the far end what kind of word follows. The choices are a cell boundary, an extended command byte or a serial address byte. On the next slot it sends the byte itself as a data character. Untagged words go straight through as data.

When the FIFO is empty or the halt input is high, the block fills the link with K28.5 comma characters. A marker and the byte it announces always go out as a pair, so a halt that arrives between them takes effect only after the byte. The character toward the encoder sits in an output register with a valid/ready handshake. While ready is low, that register holds its value and the FIFO is not read.

Top module: `tx_marker_ins`

## Requirements
- R1: While reset is low, outValid is 0 and the output register holds K28.5 (outData 8'hBC, outK 1). From the first clock edge after reset is released, outValid is 1 and stays 1.
- R2: A head word with start-of-cell 0 is sent in one slot as its own byte with outK 0. Its special/data and service bits are ignored, and the word is popped in that same slot.
- R3: A head word with start-of-cell 1 and special/data 0 is preceded by K23.7 (outData 8'hF7, outK 1), whatever its service bit.
- R4: A head word with start-of-cell 1, special/data 1 and service 0 is preceded by K27.7 (outData 8'hFB, outK 1).
- R5: A head word with start-of-cell 1, special/data 1 and service 1 is preceded by K29.7 (outData 8'hFD, outK 1).
- R6: In a marker slot the tagged word stays at the FIFO head and is not popped. In the following accepted slot its byte goes out with outK 0 and the word is popped, so the FIFO read stalls for exactly one slot.
- R7: While the FIFO is empty and no marked byte is owed, each slot carries K28.5 with outK 1 and no FIFO read takes place.
- R8: While haltReq is 1, no new word is started: slots carry K28.5 and the FIFO is not read. The exception is a byte already announced by a marker, which is still sent and popped in the next slot.
- R9: While outValid is 1 and outReady is 0, outData and outK keep their values and the FIFO is not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEmpty | input | 1 | FIFO has no word at its head |
| fifoData | input | 8 | Data byte of the head word |
| fifoSoc | input | 1 | Start-of-cell tag of the head word |
| fifoSc | input | 1 | Special/data tag of the head word |
| fifoSvs | input | 1 | Service tag of the head word |
| fifoRd | output | 1 | Pop the head word at this clock edge |
| haltReq | input | 1 | Stop starting new words |
| outValid | output | 1 | Character in the output register is valid |
| outReady | input | 1 | Encoder takes the character at this edge |
| outData | output | 8 | Character value to the encoder |
| outK | output | 1 | Character is a control (K) code |

## Verification
The controller holds one bit of state: whether a marked byte is still owed. If that bit is wrong, it shows at the ports within one accepted slot. A lost owed flag gives a second marker, or a comma, where the byte should be, and the head word is never popped. A stuck owed flag pops a tagged word with no marker in front of it. A wrong head/marker choice shows as a wrong K code in the very slot after the word reaches the head. Halt and stall errors appear as a pop count or an output value that changes during cycles in which they must stay fixed.

// File: rtl/txmark_pkg.sv
package txmark_pkg;
  localparam int CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;

  // K codes: {HGF, EDCBA}
  localparam char_t K_CELL = 8'hF7;  // K23.7
  localparam char_t K_CMD  = 8'hFB;  // K27.7
  localparam char_t K_ADDR = 8'hFD;  // K29.7
  localparam char_t K_SYNC = 8'hBC;  // K28.5

  typedef enum logic [1:0] {SRC_SYNC, SRC_MARK, SRC_WORD} src_e;

  typedef struct packed {
    logic load;
    src_e src;
  } strobe_t;
endpackage

// File: rtl/txmark_ctrl.sv
module txmark_ctrl
  import txmark_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    fifoEmpty,
  input  logic    headSoc,
  input  logic    haltReq,
  input  logic    outValid,
  input  logic    outReady,
  output strobe_t stb,
  output logic    fifoRd
);
  typedef enum logic {ST_FREE, ST_OWE} state_e;
  state_e state, nextState;
  logic advance;

  assign advance = !outValid || outReady;

  always_comb begin
    stb       = '{load: advance, src: SRC_SYNC};
    fifoRd    = 1'b0;
    nextState = state;
    if (advance) begin
      if (state == ST_OWE) begin
        stb.src   = SRC_WORD;
        fifoRd    = 1'b1;
        nextState = ST_FREE;
      end else if (!haltReq && !fifoEmpty) begin
        if (headSoc) begin
          stb.src   = SRC_MARK;
          nextState = ST_OWE;
        end else begin
          stb.src = SRC_WORD;
          fifoRd  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FREE;
    else       state <= nextState;
  end
endmodule

// File: rtl/txmark_dp.sv
module txmark_dp
  import txmark_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  char_t   headData,
  input  logic    headSc,
  input  logic    headSvs,
  output logic    outValid,
  output char_t   outData,
  output logic    outK
);
  char_t markCode;

  always_comb begin
    if (!headSc)      markCode = K_CELL;
    else if (headSvs) markCode = K_ADDR;
    else              markCode = K_CMD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= K_SYNC;
      outK     <= 1'b1;
    end else if (stb.load) begin
      outValid <= 1'b1;
      case (stb.src)
        SRC_MARK: begin outData <= markCode; outK <= 1'b1; end
        SRC_WORD: begin outData <= headData; outK <= 1'b0; end
        default:  begin outData <= K_SYNC;   outK <= 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/tx_marker_ins.sv
module tx_marker_ins
  import txmark_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEmpty,
  input  logic [CHAR_W-1:0] fifoData,
  input  logic              fifoSoc,
  input  logic              fifoSc,
  input  logic              fifoSvs,
  output logic              fifoRd,
  input  logic              haltReq,
  output logic              outValid,
  input  logic              outReady,
  output logic [CHAR_W-1:0] outData,
  output logic              outK
);
  strobe_t stb;

  txmark_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .headSoc(fifoSoc),
    .haltReq(haltReq), .outValid(outValid), .outReady(outReady),
    .stb(stb), .fifoRd(fifoRd)
  );

  txmark_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .headData(fifoData),
    .headSc(fifoSc), .headSvs(fifoSvs),
    .outValid(outValid), .outData(outData), .outK(outK)
  );
endmodule

// File: rtl/txmark_chk.sv
module txmark_chk
  import txmark_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              fifoEmpty,
  input logic              fifoRd,
  input logic              haltReq,
  input logic              outValid,
  input logic              outReady,
  input logic [CHAR_W-1:0] outData,
  input logic              outK
);
  logic isMark;
  assign isMark = outValid && outK &&
                  (outData == K_CELL || outData == K_CMD || outData == K_ADDR);

  p_valid_stays_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> outValid);

  p_pop_is_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> (outValid && !outK));

  p_marker_then_pop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isMark && outReady) |-> fifoRd);

  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !fifoRd);

  p_halt_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && !isMark) |-> !fifoRd);

  p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outData) && $stable(outK)));

  p_no_pop_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !fifoRd);
endmodule

bind tx_marker_ins txmark_chk u_chk (
  .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .fifoRd(fifoRd),
  .haltReq(haltReq), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outK(outK)
);

// File: tb/sim_tx_marker_ins.sv
`timescale 1ns/1ps
module sim_tx_marker_ins;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 1'b0;
  logic outReady = 1'b1;
  logic fifoRd, outValid, outK;
  logic [7:0] outData;

  // bench FIFO model (first-word-fall-through)
  logic [7:0] mData [0:255];
  logic [2:0] mTag  [0:255];   // {soc, sc, svs}
  logic [7:0] wrPtr = 8'd0;
  logic [7:0] rdPtr = 8'd0;
  logic fifoEmpty;
  assign fifoEmpty = (rdPtr == wrPtr);

  int checks = 0;
  int errors = 0;
  int popCnt = 0;
  bit done = 1'b0;

  // accepted-character log
  logic [8:0] logMem [0:2047];
  int logN = 0;
  logic [8:0] expC [0:31];
  int expN = 0;

  always #2 clk = ~clk;   // 250 MHz

  tx_marker_ins u0 (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .fifoData(mData[rdPtr]),
    .fifoSoc(mTag[rdPtr][2]), .fifoSc(mTag[rdPtr][1]), .fifoSvs(mTag[rdPtr][0]),
    .fifoRd(fifoRd), .haltReq(haltReq), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outK(outK)
  );

  always @(posedge clk) begin
    if (rstN && fifoRd && !fifoEmpty) begin
      rdPtr  <= rdPtr + 8'd1;
      popCnt <= popCnt + 1;
    end
    if (rstN && outValid && outReady && logN < 2048) begin
      logMem[logN] <= {outK, outData};
      logN <= logN + 1;
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input bit soc, input bit sc, input bit svs);
    mData[wrPtr] = d;
    mTag[wrPtr]  = {soc, sc, svs};
    wrPtr = wrPtr + 8'd1;
  endtask

  task automatic addExp(input bit k, input logic [7:0] d);
    expC[expN] = {k, d};
    expN++;
  endtask

  // compares the non-comma characters from logStart onward with expC
  task automatic checkStream(input int logStart, input string req);
    int e = 0;
    bit ok = 1'b1;
    for (int i = logStart; i < logN; i++) begin
      if (logMem[i] != 9'h1BC) begin
        if (e >= expN || logMem[i] != expC[e]) begin
          ok = 1'b0;
          chk(1'b0, req, {23'd0, logMem[i]}, (e < expN) ? {23'd0, expC[e]} : 32'hFFFF);
          break;
        end
        e++;
      end
    end
    if (ok) chk(e == expN, req, e, expN);
  endtask

  task automatic tReset;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 valid low in reset", outValid, 0);
    chk({outK, outData} == 9'h1BC, "R1 reset char", {outK, outData}, 9'h1BC);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b1, "R1 valid after reset", outValid, 1);
    chk({outK, outData} == 9'h1BC, "R1 first char comma", {outK, outData}, 9'h1BC);
  endtask

  task automatic tIdle;
    int p0 = popCnt;
    bit ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if ({outK, outData} != 9'h1BC) ok = 1'b0;
    end
    chk(ok, "R7 idle commas", {outK, outData}, 9'h1BC);
    chk(popCnt == p0, "R7 no pop when empty", popCnt, p0);
  endtask

  task automatic tData;
    int l0 = logN;
    int p0 = popCnt;
    expN = 0;
    @(negedge clk);
    push(8'h00, 0, 0, 0); addExp(0, 8'h00);
    push(8'hBC, 0, 1, 1); addExp(0, 8'hBC);
    push(8'hF7, 0, 1, 0); addExp(0, 8'hF7);
    push(8'hFF, 0, 0, 1); addExp(0, 8'hFF);
    repeat (12) @(negedge clk);
    checkStream(l0, "R2 plain words");
    chk(popCnt == p0 + 4, "R2 one pop per word", popCnt, p0 + 4);
  endtask

  task automatic tMarkers;
    int l0 = logN;
    expN = 0;
    @(negedge clk);
    push(8'h11, 1, 0, 0); addExp(1, 8'hF7); addExp(0, 8'h11);
    push(8'h22, 1, 1, 0); addExp(1, 8'hFB); addExp(0, 8'h22);
    push(8'h33, 1, 1, 1); addExp(1, 8'hFD); addExp(0, 8'h33);
    push(8'h44, 0, 1, 1); addExp(0, 8'h44);
    push(8'h55, 1, 0, 1); addExp(1, 8'hF7); addExp(0, 8'h55);
    repeat (16) @(negedge clk);
    checkStream(l0, "R3 R4 R5 marker stream");
  endtask

  task automatic tSlot;
    logic [7:0] r0;
    @(negedge clk);
    r0 = rdPtr;
    push(8'h5A, 1, 1, 0);
    @(negedge clk);
    chk({outK, outData} == 9'h1FB, "R4 marker slot", {outK, outData}, 9'h1FB);
    chk(rdPtr == r0, "R6 head held in marker slot", rdPtr, r0);
    @(negedge clk);
    chk({outK, outData} == 9'h05A, "R6 byte after marker", {outK, outData}, 9'h05A);
    chk(rdPtr == r0 + 8'd1, "R6 pop after marker", rdPtr, r0 + 8'd1);
  endtask

  task automatic tHalt;
    logic [7:0] r0;
    bit ok = 1'b1;
    @(negedge clk);
    haltReq = 1'b1;
    r0 = rdPtr;
    push(8'h61, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if ({outK, outData} != 9'h1BC) ok = 1'b0;
    end
    chk(ok, "R8 commas while halted", {outK, outData}, 9'h1BC);
    chk(rdPtr == r0, "R8 no pop while halted", rdPtr, r0);
    haltReq = 1'b0;
    @(negedge clk);
    chk({outK, outData} == 9'h061, "R8 resume after halt", {outK, outData}, 9'h061);
    // halt arriving between a marker and its byte
    push(8'h5B, 1, 1, 1);
    push(8'h77, 0, 0, 0);
    @(negedge clk);
    chk({outK, outData} == 9'h1FD, "R5 marker before halt", {outK, outData}, 9'h1FD);
    haltReq = 1'b1;
    r0 = rdPtr;
    @(negedge clk);
    chk({outK, outData} == 9'h05B, "R8 pair not split", {outK, outData}, 9'h05B);
    chk(rdPtr == r0 + 8'd1, "R8 owed byte popped", rdPtr, r0 + 8'd1);
    @(negedge clk);
    chk({outK, outData} == 9'h1BC, "R8 comma after pair", {outK, outData}, 9'h1BC);
    chk(rdPtr == r0 + 8'd1, "R8 halt holds next word", rdPtr, r0 + 8'd1);
    haltReq = 1'b0;
    @(negedge clk);
    chk({outK, outData} == 9'h077, "R8 next word after release", {outK, outData}, 9'h077);
  endtask

  task automatic tReady;
    logic [7:0] r0;
    bit ok = 1'b1;
    @(negedge clk);
    push(8'h01, 0, 0, 0);
    push(8'h02, 0, 0, 0);
    @(negedge clk);
    chk({outK, outData} == 9'h001, "R9 first word", {outK, outData}, 9'h001);
    outReady = 1'b0;
    r0 = rdPtr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if ({outK, outData} != 9'h001) ok = 1'b0;
    end
    chk(ok, "R9 held while not ready", {outK, outData}, 9'h001);
    chk(rdPtr == r0, "R9 no pop while not ready", rdPtr, r0);
    outReady = 1'b1;
    @(negedge clk);
    chk({outK, outData} == 9'h002, "R9 advance after ready", {outK, outData}, 9'h002);
    // stall on a marker: byte must still follow it
    push(8'h3C, 1, 0, 0);
    @(negedge clk);
    outReady = 1'b0;
    @(negedge clk);
    chk({outK, outData} == 9'h1F7, "R9 marker held", {outK, outData}, 9'h1F7);
    outReady = 1'b1;
    @(negedge clk);
    chk({outK, outData} == 9'h03C, "R3 byte after stalled marker", {outK, outData}, 9'h03C);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mData[i] = 8'h00;
      mTag[i]  = 3'b000;
    end
    repeat (3) @(negedge clk);
    tReset;
    tIdle;
    tData;
    tMarkers;
    tSlot;
    tHalt;
    tReady;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule